// File: doc/BRIEF.md
# Quantum switching decision controller

This controller picks, once per fixed-length execution quantum, which of two engines (a wide, fast "big" engine or a narrow, frugal "little" engine) runs the following quantum. At each quantum end it receives the measured cycle count of the quantum that just ran, one flag saying which engine ran it, and model estimates of what each engine would have needed. Because every quantum retires the same number of instructions, cycle counts stand in for CPI throughout.

Two running sums are kept: the cycles actually spent, and a target equal to the big-engine cycles scaled down by a programmable slowdown allowance. Their difference is the error. A proportional-integral loop turns the error, and the sum of all errors so far, into an allowed per-quantum loss. The little engine is chosen only when its cycles stay below the big-engine cycles plus that allowance. The next quantum is assumed to behave like the one just finished.

Quantum reports arrive on a valid/ready input channel and decisions leave on a valid/ready output channel with a single result register. An input is taken only when the result register is empty or is being read in the same cycle, so a stalled consumer holds off new reports. A held result keeps its value until it is taken. The slowdown and gain inputs are plain configuration pins, held steady while quanta are reported.

Top module: `qswitch_ctrl`

## Requirements
- R1: After reset, or one cycle after `clr` is high, `out_valid` is 0 and all sums restart from zero. While `clr` is high, `in_ready` is 0, and the first decision after a clear matches a freshly reset controller.
- R2: `in_ready` is 1 only when `out_valid` is 0 or `out_ready` is 1. A result not taken stays valid with an unchanged `next_little`.
- R3: Each accepted report (`in_valid` and `in_ready` high at a clock edge) sets `out_valid` on the next edge, with the decision for that report. With no new report, a taken result clears `out_valid`.
- R4: The quantum's big cycles are `obs_cyc` when `ran_big`=1, otherwise `big_est`. Actual sum grows by `obs_cyc`. Target sum grows by floor(big cycles × (65536 − `slow_frac`) / 65536), with `slow_frac` an unsigned fraction with 16 fractional bits.
- R5: The error is target sum minus actual sum, both including the current quantum.
- R6: The threshold is floor((`kp` × error + `ki` × integral) / 65536), with `kp` and `ki` signed two's-complement values with 16 fractional bits. The integral includes the current error.
- R7: The quantum's little cycles are `obs_cyc` when `ran_big`=0, otherwise `lit_est`. With net = big cycles + threshold − little cycles, `next_little` is 1 when net > 0 and 0 when net ≤ 0 (zero picks big).
- R8: The estimate for the engine that ran (`big_est` when `ran_big`=1, `lit_est` when `ran_big`=0) has no effect on any decision.
- R9: The integral saturates at −2^(INT_W−1) and 2^(INT_W−1)−1 instead of wrapping, and leaves saturation as soon as errors of the opposite sign arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of sums and result |
| in_valid | input | 1 | Quantum report present |
| in_ready | output | 1 | Report can be taken this cycle |
| obs_cyc | input | CYC_W | Measured cycles of the finished quantum |
| big_est | input | CYC_W | Estimated big-engine cycles |
| lit_est | input | CYC_W | Estimated little-engine cycles |
| ran_big | input | 1 | 1 when the finished quantum ran on the big engine |
| slow_frac | input | 16 | Allowed slowdown, unsigned fraction with 16 fractional bits |
| kp | input | GAIN_W | Proportional gain, signed, 16 fractional bits |
| ki | input | GAIN_W | Integral gain, signed, 16 fractional bits |
| out_valid | output | 1 | Decision present |
| out_ready | input | 1 | Consumer takes the decision |
| next_little | output | 1 | 1 selects the little engine for the next quantum |

## Verification
On every cycle the assertions check the channel rules: the hold of an untaken decision, blocking of input while the result is stalled or a clear is active, the one-cycle result latency, and that a zero or negative net difference never yields a little selection. The arithmetic itself — the scaled target, the error, the saturating integral and the gain products — only shows in the decisions the bench's sweeps compare against its own cycle-sum model. These sweeps cover several slowdown settings and gain pairs, the estimates that must be ignored, exact ties, and a long biased run that drives the integral into and back out of saturation.

// File: rtl/qsw_pkg.sv
package qsw_pkg;
  // Fraction bits shared by slowdown and gain inputs
  localparam int FRAC_BITS = 16;

  typedef enum logic {
    ENG_BIG    = 1'b0,
    ENG_LITTLE = 1'b1
  } eng_e;
endpackage

// File: rtl/qsw_accum.sv
// Running sums of actual and target cycles, and their difference.
module qsw_accum
  import qsw_pkg::*;
#(
  parameter int CYC_W = 16,
  parameter int SUM_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    step,
  input  logic [CYC_W-1:0]        obs,
  input  logic [CYC_W-1:0]        big_q,
  input  logic [FRAC_BITS-1:0]    slow,
  output logic signed [SUM_W:0]   err
);
  localparam int SCL_W = FRAC_BITS + 1;
  localparam int PRD_W = CYC_W + SCL_W;

  logic [SUM_W-1:0] act_q, tgt_q, act_n, tgt_n;
  logic [SCL_W-1:0] scale;
  logic [PRD_W-1:0] prod, inc;

  assign scale = {1'b1, {FRAC_BITS{1'b0}}} - {1'b0, slow};
  assign prod  = PRD_W'(big_q) * PRD_W'(scale);
  assign inc   = prod >> FRAC_BITS;
  assign act_n = act_q + SUM_W'(obs);
  assign tgt_n = tgt_q + SUM_W'(inc);
  assign err   = $signed({1'b0, tgt_n}) - $signed({1'b0, act_n});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      tgt_q <= '0;
    end else if (clr) begin
      act_q <= '0;
      tgt_q <= '0;
    end else if (step) begin
      act_q <= act_n;
      tgt_q <= tgt_n;
    end
  end
endmodule

// File: rtl/qsw_pi.sv
// Proportional-integral threshold with a saturating integral.
module qsw_pi
  import qsw_pkg::*;
#(
  parameter int SUM_W  = 32,
  parameter int INT_W  = 40,
  parameter int GAIN_W = 20,
  parameter int PROD_W = 61
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      step,
  input  logic signed [SUM_W:0]     err,
  input  logic signed [GAIN_W-1:0]  kp,
  input  logic signed [GAIN_W-1:0]  ki,
  output logic signed [PROD_W-1:0]  thr
);
  localparam int EW = SUM_W + 1;
  localparam int IW = ((INT_W > EW) ? INT_W : EW) + 1;
  localparam logic signed [IW-1:0] IMAX =
    $signed({{(IW-INT_W+1){1'b0}}, {(INT_W-1){1'b1}}});
  localparam logic signed [IW-1:0] IMIN =
    $signed({{(IW-INT_W+1){1'b1}}, {(INT_W-1){1'b0}}});

  logic signed [INT_W-1:0]  integ_q, integ_n;
  logic signed [IW-1:0]     ie, ee, isum;
  logic signed [PROD_W-1:0] kpx, kix, errx, intx, psum;

  assign ie   = $signed({{(IW-INT_W){integ_q[INT_W-1]}}, integ_q});
  assign ee   = $signed({{(IW-EW){err[EW-1]}}, err});
  assign isum = ie + ee;

  always_comb begin
    if (isum > IMAX)      integ_n = IMAX[INT_W-1:0];
    else if (isum < IMIN) integ_n = IMIN[INT_W-1:0];
    else                  integ_n = isum[INT_W-1:0];
  end

  assign kpx  = $signed({{(PROD_W-GAIN_W){kp[GAIN_W-1]}}, kp});
  assign kix  = $signed({{(PROD_W-GAIN_W){ki[GAIN_W-1]}}, ki});
  assign errx = $signed({{(PROD_W-EW){err[EW-1]}}, err});
  assign intx = $signed({{(PROD_W-INT_W){integ_n[INT_W-1]}}, integ_n});
  assign psum = kpx * errx + kix * intx;
  assign thr  = psum >>> FRAC_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     integ_q <= '0;
    else if (clr)   integ_q <= '0;
    else if (step)  integ_q <= integ_n;
  end
endmodule

// File: rtl/qsw_pick.sv
// Net difference and engine choice; a zero net keeps the big engine.
module qsw_pick
  import qsw_pkg::*;
#(
  parameter int CYC_W  = 16,
  parameter int PROD_W = 61
) (
  input  logic [CYC_W-1:0]          big_q,
  input  logic [CYC_W-1:0]          lit_q,
  input  logic signed [PROD_W-1:0]  thr,
  output logic signed [PROD_W:0]    net,
  output eng_e                      choice
);
  logic signed [PROD_W:0] bx, lx, tx;

  assign bx  = $signed({{(PROD_W+1-CYC_W){1'b0}}, big_q});
  assign lx  = $signed({{(PROD_W+1-CYC_W){1'b0}}, lit_q});
  assign tx  = $signed({thr[PROD_W-1], thr});
  assign net = bx + tx - lx;

  always_comb begin
    if (!net[PROD_W] && (net != '0)) choice = ENG_LITTLE;
    else                             choice = ENG_BIG;
  end
endmodule

// File: rtl/qswitch_ctrl.sv
module qswitch_ctrl
  import qsw_pkg::*;
#(
  parameter int CYC_W  = 16,
  parameter int SUM_W  = 32,
  parameter int INT_W  = 40,
  parameter int GAIN_W = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [CYC_W-1:0]          obs_cyc,
  input  logic [CYC_W-1:0]          big_est,
  input  logic [CYC_W-1:0]          lit_est,
  input  logic                      ran_big,
  input  logic [15:0]               slow_frac,
  input  logic signed [GAIN_W-1:0]  kp,
  input  logic signed [GAIN_W-1:0]  ki,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic                      next_little
);
  localparam int EW     = SUM_W + 1;
  localparam int WIDEST = (EW > INT_W) ? EW : INT_W;
  localparam int PROD_W = GAIN_W + WIDEST + 1;

  logic                     acc;
  logic [CYC_W-1:0]         big_q, lit_q;
  logic signed [SUM_W:0]    err_w;
  logic signed [PROD_W-1:0] thr_w;
  logic signed [PROD_W:0]   net_w;
  eng_e                     choice_w;

  assign in_ready = (!out_valid || out_ready) && !clr;
  assign acc      = in_valid && in_ready;
  assign big_q    = ran_big ? obs_cyc : big_est;
  assign lit_q    = ran_big ? lit_est : obs_cyc;

  qsw_accum #(.CYC_W(CYC_W), .SUM_W(SUM_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(acc),
    .obs(obs_cyc), .big_q(big_q), .slow(slow_frac[FRAC_BITS-1:0]),
    .err(err_w)
  );

  qsw_pi #(.SUM_W(SUM_W), .INT_W(INT_W), .GAIN_W(GAIN_W), .PROD_W(PROD_W)) u_pi (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step(acc),
    .err(err_w), .kp(kp), .ki(ki), .thr(thr_w)
  );

  qsw_pick #(.CYC_W(CYC_W), .PROD_W(PROD_W)) u_pick (
    .big_q(big_q), .lit_q(lit_q), .thr(thr_w),
    .net(net_w), .choice(choice_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      next_little <= 1'b0;
    end else if (clr) begin
      out_valid   <= 1'b0;
      next_little <= 1'b0;
    end else if (acc) begin
      out_valid   <= 1'b1;
      next_little <= (choice_w == ENG_LITTLE);
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/qswitch_ctrl_chk.sv
module qswitch_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic clr,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic next_little,
  input logic net_neg,
  input logic net_zero
);
  p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid);
  p_clr_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !in_ready);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr) |=> (out_valid && $stable(next_little)));
  p_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  p_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !(in_valid && in_ready)) |=> !out_valid);
  p_zero_big_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && net_zero) |=> !next_little);
  p_neg_big_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && net_neg) |=> !next_little);
endmodule

bind qswitch_ctrl qswitch_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr),
  .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .next_little(next_little),
  .net_neg(net_w[PROD_W]), .net_zero(net_w == '0)
);

// File: tb/qswitch_ctrl_bench.sv
module qswitch_ctrl_bench;
  localparam int CW = 16;
  localparam int SW = 32;
  localparam int IWB = 24;
  localparam int GW = 20;
  localparam longint IMAXB = (64'sd1 <<< (IWB-1)) - 1;
  localparam longint IMINB = -(64'sd1 <<< (IWB-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [CW-1:0] obs_cyc = '0, big_est = '0, lit_est = '0;
  logic ran_big = 1'b1;
  logic [15:0] slow_frac = '0;
  logic signed [GW-1:0] kp = '0, ki = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic next_little;

  int total = 0;
  int bad = 0;
  longint m_act, m_tgt, m_int, g_kp, g_ki, g_slow;
  bit m_little;
  int unsigned seed = 32'h1234_5678;

  always #10 clk = ~clk;

  qswitch_ctrl #(.CYC_W(CW), .SUM_W(SW), .INT_W(IWB), .GAIN_W(GW)) u_qswitch_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .obs_cyc(obs_cyc), .big_est(big_est), .lit_est(lit_est), .ran_big(ran_big),
    .slow_frac(slow_frac), .kp(kp), .ki(ki), .out_valid(out_valid),
    .out_ready(out_ready), .next_little(next_little)
  );

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    m_act = 0; m_tgt = 0; m_int = 0; m_little = 1'b0;
  endtask

  function automatic bit model_step(longint obs, longint be, longint le, bit onbig);
    longint bq, lq, err, thr, net;
    bq = onbig ? obs : be;
    lq = onbig ? le : obs;
    m_act += obs;
    m_tgt += (bq * (65536 - g_slow)) >>> 16;
    err = m_tgt - m_act;
    m_int += err;
    if (m_int > IMAXB) m_int = IMAXB;
    if (m_int < IMINB) m_int = IMINB;
    thr = (g_kp * err + g_ki * m_int) >>> 16;
    net = bq + thr - lq;
    return net > 0;
  endfunction

  task automatic config_set(input longint s, input longint p, input longint i);
    g_slow = s; g_kp = p; g_ki = i;
    @(negedge clk);
    slow_frac = s[15:0]; kp = p[GW-1:0]; ki = i[GW-1:0];
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    #1 chk("R1", "in_ready during clear", in_ready, 0);
    @(negedge clk);
    clr = 1'b0;
    chk("R1", "out_valid after clear", out_valid, 0);
    model_clear();
  endtask

  task automatic send(input longint obs, input longint be, input longint le,
                      input bit onbig, input string req);
    bit exp;
    @(negedge clk);
    obs_cyc = obs[CW-1:0]; big_est = be[CW-1:0]; lit_est = le[CW-1:0];
    ran_big = onbig; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    exp = model_step(obs, be, le, onbig);
    m_little = exp;
    chk("R3", "out_valid after accept", out_valid, 1);
    chk(req, "next_little", next_little, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint slows [4] = '{655, 3277, 6554, 13107};
    longint kps [3] = '{65536, 131072, 32768};
    longint kis [3] = '{64, 131, 0};
    bit held;

    model_clear();
    g_slow = 0; g_kp = 0; g_ki = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", out_valid, 0);
    chk("R1", "in_ready after reset", in_ready, 1);

    // R4 R5 R6 R7: sweep of slowdown settings and gain pairs
    for (int s = 0; s < 4; s++) begin
      for (int g = 0; g < 3; g++) begin
        config_set(slows[s], kps[g], kis[g]);
        do_clear();
        for (int q = 0; q < 12; q++) begin
          longint o, b, l;
          o = 800 + (rnd() % 2000);
          b = 800 + (rnd() % 1500);
          l = 1000 + (rnd() % 2500);
          send(o, b, l, !m_little, "R4 R5 R6 R7");
        end
      end
    end

    // R8: estimate of the engine that ran is ignored (model never reads it)
    config_set(3277, 65536, 64);
    do_clear();
    for (int q = 0; q < 8; q++) begin
      longint o;
      o = 900 + (rnd() % 1500);
      if (q % 2 == 0) send(o, (q % 4 == 0) ? 0 : 65535, 1200 + q * 40, 1'b1, "R8");
      else            send(o, 1000 + q * 30, (q % 4 == 1) ? 65535 : 0, 1'b0, "R8");
    end

    // R7: exact tie picks big, +1 picks little, -1 picks big
    config_set(3277, 0, 0);
    do_clear();
    send(1000, 0, 1000, 1'b1, "R7 tie");
    send(1000, 0, 999,  1'b1, "R7 plus one");
    send(1000, 0, 1001, 1'b1, "R7 minus one");
    send(1500, 1500, 0, 1'b0, "R7 tie little ran");

    // R2: stalled consumer holds result and blocks input
    config_set(6554, 65536, 64);
    do_clear();
    @(negedge clk);
    out_ready = 1'b0;
    send(1200, 900, 1300, 1'b1, "R2");
    held = next_little;
    @(negedge clk);
    obs_cyc = 16'd50; ran_big = 1'b1; lit_est = 16'd4000; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk("R2", "in_ready while stalled", in_ready, 0);
      chk("R2", "out_valid held", out_valid, 1);
      chk("R2", "next_little held", next_little, held);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    #1 chk("R2", "in_ready on take", in_ready, 1);
    @(negedge clk);
    chk("R3", "out_valid drops after take", out_valid, 0);
    send(1100, 1000, 1400, 1'b1, "R2 after stall");

    // R9: integral saturates on a long negative run, then recovers
    config_set(32768, 0, 65536);
    do_clear();
    for (int q = 0; q < 40; q++) send(60000, 0, 0, 1'b1, "R9 saturate");
    config_set(0, 0, 65536);
    for (int q = 0; q < 40; q++) send(100, 60000, 0, 1'b0, "R9 recover");

    // R1: clear restores fresh behaviour
    config_set(655, 131072, 131);
    for (int q = 0; q < 5; q++) send(3000, 800, 900, 1'b1, "R1 bias");
    do_clear();
    send(1000, 1200, 1050, 1'b1, "R1 fresh");
    send(1010, 1000, 1300, 1'b0, "R1 fresh");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule